// File: doc/BRIEF.md
# Serial Three-Line Loader with Dual Frequency Store

This block receives control words over a three-line serial link (data, shift clock, frame enable) and files each word into one of three holding registers: two frequency words and one reference word. The two frequency words are held side by side, and a select pin picks which one drives the divider and phase-detector control fields. A loop can therefore hop between two channels with one pin, while the idle word or the reference word is rewritten in the background.

All three serial lines are brought into the system clock domain through a synchronizer and edge detectors. A small state machine tracks each frame. ST_IDLE moves to ST_SHIFT once the synchronized enable is high. ST_SHIFT moves to ST_COMMIT on a detected enable fall. ST_COMMIT returns to ST_IDLE, or to ST_SHIFT if enable is already high again. ST_COMMIT lasts one cycle, and in it the two bits shifted in last are decoded as a destination address and the register chosen is written. The shift register keeps its contents between frames. A reference frame of 18 bits therefore fills the low 18 positions that its fields use.

Top module: `tri_wire_loader`

## Requirements
- R1: Each rising edge of `ser_clk` seen while `ser_en` is high shifts `ser_data` into a 24-bit register, so the first bit sent ends up most significant. Edges of `ser_clk` while `ser_en` is low shift nothing.
- R2: A transfer happens only after a falling edge of `ser_en`. A `ser_clk` rise that reaches the synchronized domain in the same cycle as that enable fall is not shifted.
- R3: The address is sr[1:0] = {C2,C1}, with C2 sent before C1. Code 00 writes frequency word 1 and code 10 writes frequency word 2. The frequency payload is sr[23:2]: sense at bit 23, M ratio at [22:8], A ratio at [7:4], and gain at [3:2].
- R4: Code 11 writes the reference word from sr[17:2]: prescaler mode at bit 17, R ratio at [16:4], and phase-detector mode at [3:2].
- R5: Code 01 writes no register and leaves every output unchanged.
- R6: With `sel_f1` high the frequency outputs show word 1, and with it low they show word 2. The change is combinational and needs no reload.
- R7: Writing the word that is not selected leaves the active outputs unchanged.
- R8: After reset, all stored words and all outputs are zero.
- R9: When `ser_en` falls between two system clock edges, the new word first shows at the outputs after the fourth rising `clk` edge that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_data | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial shift clock (sampled) |
| ser_en | input | 1 | Frame enable, high during a frame |
| sel_f1 | input | 1 | High selects frequency word 1, low selects word 2 |
| m_ratio | output | 15 | Main counter ratio of the active word |
| a_ratio | output | 4 | Swallow counter ratio of the active word |
| pd_gain | output | 2 | Phase-detector gain code of the active word |
| pd_sense | output | 1 | Phase-detector sense of the active word |
| r_ratio | output | 13 | Reference divider ratio |
| pd_mode | output | 2 | Phase-detector output/lock mode bits |
| presc_sel | output | 1 | Prescaler modulus select |

## Verification
Two pairs of events can fall in the same cycle. The first is a shift-clock rise and the enable fall. The bench provokes this by raising `ser_clk` and dropping `ser_en` in the same drive step after a full 24-bit frame. The stored word must match the frame without the extra bit. The second is a select toggle and a commit landing together, and their timing is judged by the bench's behavioural model, which is compared against every output on every clock.

// File: rtl/twl_pkg.sv
package twl_pkg;
    localparam int SR_W   = 24;
    localparam int ADDR_W = 2;
    localparam int M_W    = 15;
    localparam int A_W    = 4;
    localparam int G_W    = 2;
    localparam int R_W    = 13;
    localparam int PD_W   = 2;
    localparam int FREQ_W = 1 + M_W + A_W + G_W;
    localparam int REF_W  = 1 + R_W + PD_W;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } ld_state_t;

    typedef enum logic [ADDR_W-1:0] {
        AD_F1    = 2'b00,
        AD_SPARE = 2'b01,
        AD_F2    = 2'b10,
        AD_REF   = 2'b11
    } dest_t;

    typedef struct packed {
        logic           sense;
        logic [M_W-1:0] m;
        logic [A_W-1:0] a;
        logic [G_W-1:0] g;
    } freq_t;

    typedef struct packed {
        logic            presc;
        logic [R_W-1:0]  r;
        logic [PD_W-1:0] pd;
    } ref_t;
endpackage

// File: rtl/twl_sync.sv
module twl_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[i] <= '0;
                    else        stg[i] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[i] <= '0;
                    else        stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/twl_shifter.sv
module twl_shifter
    import twl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            d_s,
    input  logic            ck_s,
    input  logic            en_s,
    output logic [SR_W-1:0] sr_q,
    output logic            commit
);
    ld_state_t state, state_nx;
    logic ck_p, en_p;
    logic ck_rise, en_fall;

    assign ck_rise = ck_s & ~ck_p;
    assign en_fall = en_p & ~en_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ck_p <= 1'b0;
            en_p <= 1'b0;
        end else begin
            ck_p <= ck_s;
            en_p <= en_s;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (en_s)    state_nx = ST_SHIFT;
            ST_SHIFT:  if (en_fall) state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = en_s ? ST_SHIFT : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              sr_q <= '0;
        else if (ck_rise && en_s) sr_q <= {sr_q[SR_W-2:0], d_s};
    end

    always_comb commit = (state == ST_COMMIT);

    a_r1_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_rise && en_s) |=> (sr_q == {$past(sr_q[SR_W-2:0]), $past(d_s)}));

    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(ck_rise && en_s) |=> $stable(sr_q));

    a_r2_commit_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(commit) |-> $past(en_p && !en_s));
endmodule

// File: rtl/twl_bank.sv
module twl_bank
    import twl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            commit,
    input  logic [SR_W-1:0] sr_q,
    output freq_t           f1_q,
    output freq_t           f2_q,
    output ref_t            ref_q
);
    dest_t dest;
    freq_t f_pay;
    ref_t  r_pay;

    assign dest  = dest_t'(sr_q[ADDR_W-1:0]);
    assign f_pay = freq_t'(sr_q[FREQ_W+ADDR_W-1:ADDR_W]);
    assign r_pay = ref_t'(sr_q[REF_W+ADDR_W-1:ADDR_W]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f1_q  <= '0;
            f2_q  <= '0;
            ref_q <= '0;
        end else if (commit) begin
            unique case (dest)
                AD_F1:    f1_q  <= f_pay;
                AD_F2:    f2_q  <= f_pay;
                AD_REF:   ref_q <= r_pay;
                AD_SPARE: ;
                default:  ;
            endcase
        end
    end

    a_r3_f1_load: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && sr_q[1:0] == 2'b00) |=> (f1_q == $past(sr_q[23:2]) && $stable(f2_q)));

    a_r3_f2_load: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && sr_q[1:0] == 2'b10) |=> (f2_q == $past(sr_q[23:2]) && $stable(f1_q)));

    a_r4_ref_load: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && sr_q[1:0] == 2'b11) |=> (ref_q == $past(sr_q[17:2])));

    a_r5_spare_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && sr_q[1:0] == 2'b01) |=> ($stable(f1_q) && $stable(f2_q) && $stable(ref_q)));
endmodule

// File: rtl/tri_wire_loader.sv
module tri_wire_loader
    import twl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ser_data,
    input  logic            ser_clk,
    input  logic            ser_en,
    input  logic            sel_f1,
    output logic [M_W-1:0]  m_ratio,
    output logic [A_W-1:0]  a_ratio,
    output logic [G_W-1:0]  pd_gain,
    output logic            pd_sense,
    output logic [R_W-1:0]  r_ratio,
    output logic [PD_W-1:0] pd_mode,
    output logic            presc_sel
);
    logic [2:0]      pins_s;
    logic [SR_W-1:0] sr_q;
    logic            commit;
    freq_t           f1_q, f2_q, act;
    ref_t            ref_q;

    twl_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ser_data, ser_clk, ser_en}),
        .dout (pins_s)
    );

    twl_shifter u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .d_s   (pins_s[2]),
        .ck_s  (pins_s[1]),
        .en_s  (pins_s[0]),
        .sr_q  (sr_q),
        .commit(commit)
    );

    twl_bank u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .commit(commit),
        .sr_q  (sr_q),
        .f1_q  (f1_q),
        .f2_q  (f2_q),
        .ref_q (ref_q)
    );

    assign act       = sel_f1 ? f1_q : f2_q;
    assign m_ratio   = act.m;
    assign a_ratio   = act.a;
    assign pd_gain   = act.g;
    assign pd_sense  = act.sense;
    assign r_ratio   = ref_q.r;
    assign pd_mode   = ref_q.pd;
    assign presc_sel = ref_q.presc;

    a_r7_active_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && sr_q[1:0] == 2'b10 && sel_f1) |=>
            (!sel_f1 || ($stable(m_ratio) && $stable(a_ratio) && $stable(pd_gain) && $stable(pd_sense))));
endmodule

// File: tb/tb_tri_wire_loader.sv
module tb_tri_wire_loader;
    import twl_pkg::*;
    localparam int CLK_NS = 10;

    logic clk = 0, rst_n = 0;
    logic ser_data = 0, ser_clk = 0, ser_en = 0, sel_f1 = 1;
    logic [M_W-1:0]  m_ratio;
    logic [A_W-1:0]  a_ratio;
    logic [G_W-1:0]  pd_gain;
    logic            pd_sense;
    logic [R_W-1:0]  r_ratio;
    logic [PD_W-1:0] pd_mode;
    logic            presc_sel;

    tri_wire_loader dut (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
        .ser_en(ser_en), .sel_f1(sel_f1), .m_ratio(m_ratio), .a_ratio(a_ratio),
        .pd_gain(pd_gain), .pd_sense(pd_sense), .r_ratio(r_ratio),
        .pd_mode(pd_mode), .presc_sel(presc_sel)
    );

    always #(CLK_NS/2) clk = ~clk;

    int checks = 0, errors = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // behavioural reference: pin history, pending transfer, stored words
    bit [2:0]  hd, hc, he;
    bit [23:0] msr;
    bit        pend;
    int        mf1, mf2, mref;

    always @(posedge clk) begin
        if (!rst_n) begin
            hd <= 0; hc <= 0; he <= 0; msr <= 0; pend <= 0;
            mf1 <= 0; mf2 <= 0; mref <= 0;
        end else begin
            if (hc[1] && !hc[2] && he[1]) msr <= {msr[22:0], hd[1]};
            pend <= he[2] && !he[1];
            if (pend) begin
                if (msr[1:0] == 2'b00) mf1  <= int'(msr[23:2]);
                if (msr[1:0] == 2'b10) mf2  <= int'(msr[23:2]);
                if (msr[1:0] == 2'b11) mref <= int'(msr[17:2]);
            end
            hd <= {hd[1:0], ser_data};
            hc <= {hc[1:0], ser_clk};
            he <= {he[1:0], ser_en};
        end
    end

    function automatic int act_word();
        return int'({pd_sense, m_ratio, a_ratio, pd_gain});
    endfunction
    function automatic int ref_word();
        return int'({presc_sel, r_ratio, pd_mode});
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R6 active word vs model", act_word(), sel_f1 ? mf1 : mf2);
            chk("R4 reference word vs model", ref_word(), mref);
        end
    end

    task automatic tick(input int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    function automatic bit [23:0] ffr(input bit s, input int m, input int a, input int g, input bit [1:0] ad);
        return {s, m[14:0], a[3:0], g[1:0], ad};
    endfunction
    function automatic bit [23:0] rfr(input bit p, input int r, input int pd);
        return {6'b0, p, r[12:0], pd[1:0], 2'b11};
    endfunction

    task automatic shift_bits(input bit [23:0] fr, input int n);
        ser_en = 1; tick(3);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = fr[i]; tick(2);
            ser_clk = 1; tick(3);
            ser_clk = 0; tick(3);
        end
    endtask

    task automatic end_frame();
        ser_en = 0; tick(8);
    endtask

    task automatic send(input bit [23:0] fr, input int n);
        shift_bits(fr, n);
        end_frame();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        // R8: reset state
        chk("R8 active word after reset", act_word(), 0);
        chk("R8 reference after reset", ref_word(), 0);
        rst_n = 1; tick(2);
        chk("R8 active word after release", act_word(), 0);

        // R3: load word 1 while it is active
        sel_f1 = 1;
        send(ffr(1, 'h5A5A, 9, 2, 2'b00), 24);
        chk("R3 m_ratio word1", m_ratio, 'h5A5A);
        chk("R3 a_ratio word1", a_ratio, 9);
        chk("R3 gain word1", pd_gain, 2);
        chk("R3 sense word1", pd_sense, 1);

        // R9: latency of a word 2 load
        sel_f1 = 0; #1;
        shift_bits(ffr(0, 'h1234, 5, 1, 2'b10), 24);
        ser_en = 0; tick(3);
        chk("R9 old value after three edges", m_ratio, 0);
        tick(1);
        chk("R9 new value after four edges", m_ratio, 'h1234);
        chk("R3 a_ratio word2", a_ratio, 5);
        tick(5);

        // R6: select switching without reload
        sel_f1 = 1; #1;
        chk("R6 select word1", m_ratio, 'h5A5A);
        sel_f1 = 0; #1;
        chk("R6 select word2", m_ratio, 'h1234);

        // R7: rewrite inactive word 2 while word 1 drives
        sel_f1 = 1; #1;
        send(ffr(1, 'h7001, 15, 3, 2'b10), 24);
        chk("R7 active word1 kept", m_ratio, 'h5A5A);
        sel_f1 = 0; #1;
        chk("R7 word2 rewritten", m_ratio, 'h7001);
        chk("R7 word2 gain", pd_gain, 3);

        // R4: reference frame of 18 bits
        send(rfr(1, 'h1ABC, 2), 18);
        chk("R4 r_ratio", r_ratio, 'h1ABC);
        chk("R4 pd_mode", pd_mode, 2);
        chk("R4 presc_sel", presc_sel, 1);

        // R5: spare address changes nothing
        send(ffr(0, 'h0F0F, 3, 0, 2'b01), 24);
        chk("R5 word2 unchanged", m_ratio, 'h7001);
        sel_f1 = 1; #1;
        chk("R5 word1 unchanged", m_ratio, 'h5A5A);
        chk("R5 reference unchanged", r_ratio, 'h1ABC);

        // R1: clocks with enable low are not shifted (would turn address into 11)
        for (int k = 0; k < 2; k++) begin
            ser_data = 1; tick(2);
            ser_clk = 1; tick(3);
            ser_clk = 0; tick(3);
        end
        ser_en = 1; tick(4);
        end_frame();
        chk("R1 reference unchanged after idle clocks", ref_word(), int'({1'b1, 13'h1ABC, 2'd2}));
        chk("R1 word1 unchanged after idle clocks", m_ratio, 'h5A5A);

        // R2: clock rise coincident with enable fall is not shifted
        shift_bits(ffr(0, 'h2468, 6, 1, 2'b00), 24);
        ser_data = 1; tick(2);
        ser_clk = 1; ser_en = 0; tick(3);
        ser_clk = 0; tick(8);
        chk("R2 word1 from coincident frame", m_ratio, 'h2468);
        chk("R2 a_ratio from coincident frame", a_ratio, 6);

        // select toggled while a word 1 commit lands
        shift_bits(ffr(1, 'h3333, 1, 0, 2'b00), 24);
        ser_en = 0; tick(3);
        sel_f1 = 0; tick(1);
        sel_f1 = 1; tick(4);
        chk("R6 word1 after toggle during commit", m_ratio, 'h3333);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule